// File: doc/BRIEF.md
# Conditional Branch Resolution Unit

This block decides, in the execute stage, whether the instruction now there redirects the program counter. Decode has already sorted every branch opcode into one of five condition classes and presents them as a 5-bit class vector. The integer comparator supplies three flags: equal, greater-than and less-than. The block gates the classes with instruction-valid and the kill signal, tests each class against its own flag, and ORs the results. It produces two outputs. One is the pure condition result. The other also rises whenever the next stage asks for a reissue.

Unconditional transfers share class 0 with the microcode program-counter write. The microcode write arrives on its own input and enters class 0 before gating. A stall caused by a load-use hazard or a cache read miss reaches the block as a dropped instruction-valid, so such a stall can never produce a taken result.

The block also carries the 2-bit load/store type field toward the data cache. It selects the microcode-supplied type while microcode is busy and no cache request is pending. Otherwise it passes the decoded type. All outputs are combinational.

Top module: `branch_resolve`

## Requirements
- R1: Class 4 (bit 4 of `grpQual`) resolves taken exactly when `cmpEq` is 1.
- R2: Class 3 (bit 3) resolves taken exactly when `cmpEq` is 0.
- R3: Class 2 (bit 2) resolves taken exactly when `cmpGt` is 1.
- R4: Class 1 (bit 1) resolves taken exactly when `cmpLt` is 1.
- R5: Class 0 (bit 0) resolves taken whatever the comparison flags are.
- R6: `ucodeWrPc` behaves exactly like class 0, including its gating.
- R7: When `instValid` is 0 or `killInst` is 1, no class resolves taken: `takenCond` is 0, and `takenAny` follows `reissue` alone.
- R8: `reissue` drives `takenAny` to 1 under any inputs. It has no effect on `takenCond`.
- R9: `lsType` equals `ucodeLsType` when `ucodeBusy` is 1 and `cacheReq` is 0. Otherwise it equals `rawLsType`.
- R10: When several classes are active at once, the result is taken if any one active class meets its condition.
- R11: In the same cycle, `takenAny` equals `takenCond` OR `reissue`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| grpQual | input | 5 | Condition-class vector from decode; bit n selects class n |
| cmpEq | input | 1 | Comparator equal flag |
| cmpGt | input | 1 | Comparator greater-than flag |
| cmpLt | input | 1 | Comparator less-than flag |
| instValid | input | 1 | Execute-stage instruction valid |
| killInst | input | 1 | Execute-stage instruction killed |
| reissue | input | 1 | Reissue request from the next stage |
| ucodeWrPc | input | 1 | Microcode program-counter write |
| cacheReq | input | 1 | Cache request pending; selects the decoded type |
| ucodeBusy | input | 1 | Microcode is driving the data cache |
| rawLsType | input | 2 | Decoded load/store type |
| ucodeLsType | input | 2 | Microcode-supplied load/store type |
| takenCond | output | 1 | Branch taken by condition |
| takenAny | output | 1 | Branch taken, including reissue |
| lsType | output | 2 | Selected load/store type |

## Verification
No state is stored, so a fault in the class gating, the flag pairing or the type select shows at the outputs in the same cycle as the input pattern that exposes it. The flag pairing is exposed by driving each class alone against all eight flag combinations. The gating is exposed by repeating those patterns with the instruction invalid or killed. Reissue is checked separately on both outputs, so that forcing `takenCond` by mistake is caught as well as failing to force `takenAny`.

// File: rtl/branch_resolve_pkg.sv
package branch_resolve_pkg;
  localparam int NUM_CLASSES = 5;
  localparam int LS_TYPE_W   = 2;

  typedef enum logic [2:0] {
    CLS_UNCOND = 3'd0,
    CLS_LT     = 3'd1,
    CLS_GT     = 3'd2,
    CLS_NE     = 3'd3,
    CLS_EQ     = 3'd4
  } class_e;

  typedef struct packed {
    logic [NUM_CLASSES-1:0] classHit;
    logic                   forceTaken;
    logic                   pickUcode;
  } strobes_t;
endpackage

// File: rtl/branch_resolve_ctrl.sv
module branch_resolve_ctrl
  import branch_resolve_pkg::*;
(
  input  logic [NUM_CLASSES-1:0] grpQual,
  input  logic                   cmpEq,
  input  logic                   cmpGt,
  input  logic                   cmpLt,
  input  logic                   instValid,
  input  logic                   killInst,
  input  logic                   reissue,
  input  logic                   ucodeWrPc,
  input  logic                   cacheReq,
  input  logic                   ucodeBusy,
  output strobes_t               strobes
);
  logic                   liveInst;
  logic [NUM_CLASSES-1:0] classIn;
  logic [NUM_CLASSES-1:0] classGated;
  logic [NUM_CLASSES-1:0] classCond;

  assign liveInst = instValid & ~killInst;

  // The microcode PC write enters the unconditional class before gating.
  assign classIn = grpQual | {{(NUM_CLASSES-1){1'b0}}, ucodeWrPc};

  generate
    for (genvar g = 0; g < NUM_CLASSES; g++) begin : g_class
      assign classGated[g] = classIn[g] & liveInst;
      if (g == int'(CLS_EQ)) begin : g_eq
        assign classCond[g] = cmpEq;
      end else if (g == int'(CLS_NE)) begin : g_ne
        assign classCond[g] = ~cmpEq;
      end else if (g == int'(CLS_GT)) begin : g_gt
        assign classCond[g] = cmpGt;
      end else if (g == int'(CLS_LT)) begin : g_lt
        assign classCond[g] = cmpLt;
      end else begin : g_uncond
        assign classCond[g] = 1'b1;
      end
    end
  endgenerate

  assign strobes.classHit   = classGated & classCond;
  assign strobes.forceTaken = reissue;
  assign strobes.pickUcode  = ucodeBusy & ~cacheReq;

  always_comb begin
    if (!liveInst)
      assert_gate_R7: assert (strobes.classHit == '0)
        else $error("class hit while instruction not live");
  end
endmodule

// File: rtl/branch_resolve_dp.sv
module branch_resolve_dp
  import branch_resolve_pkg::*;
(
  input  strobes_t               strobes,
  input  logic [LS_TYPE_W-1:0]   rawLsType,
  input  logic [LS_TYPE_W-1:0]   ucodeLsType,
  output logic                   takenCond,
  output logic                   takenAny,
  output logic [LS_TYPE_W-1:0]   lsType
);
  assign takenCond = |strobes.classHit;
  assign takenAny  = takenCond | strobes.forceTaken;
  assign lsType    = strobes.pickUcode ? ucodeLsType : rawLsType;
endmodule

// File: rtl/branch_resolve.sv
module branch_resolve
  import branch_resolve_pkg::*;
(
  input  logic [NUM_CLASSES-1:0] grpQual,
  input  logic                   cmpEq,
  input  logic                   cmpGt,
  input  logic                   cmpLt,
  input  logic                   instValid,
  input  logic                   killInst,
  input  logic                   reissue,
  input  logic                   ucodeWrPc,
  input  logic                   cacheReq,
  input  logic                   ucodeBusy,
  input  logic [LS_TYPE_W-1:0]   rawLsType,
  input  logic [LS_TYPE_W-1:0]   ucodeLsType,
  output logic                   takenCond,
  output logic                   takenAny,
  output logic [LS_TYPE_W-1:0]   lsType
);
  strobes_t strobes;

  branch_resolve_ctrl u_ctrl (
    .grpQual   (grpQual),
    .cmpEq     (cmpEq),
    .cmpGt     (cmpGt),
    .cmpLt     (cmpLt),
    .instValid (instValid),
    .killInst  (killInst),
    .reissue   (reissue),
    .ucodeWrPc (ucodeWrPc),
    .cacheReq  (cacheReq),
    .ucodeBusy (ucodeBusy),
    .strobes   (strobes)
  );

  branch_resolve_dp u_dp (
    .strobes     (strobes),
    .rawLsType   (rawLsType),
    .ucodeLsType (ucodeLsType),
    .takenCond   (takenCond),
    .takenAny    (takenAny),
    .lsType      (lsType)
  );

  always_comb begin
    if (reissue)
      assert_reissue_forces_R8: assert (takenAny)
        else $error("reissue did not force taken");
    if (instValid && !killInst && (grpQual[0] || ucodeWrPc))
      assert_uncond_taken_R5: assert (takenCond)
        else $error("unconditional class not taken");
    if (instValid && !killInst && grpQual == 5'b01000)
      assert_ne_class_R2: assert (takenCond == !cmpEq)
        else $error("not-equal class mismatch");
    if (ucodeBusy && !cacheReq)
      assert_type_sel_R9: assert (lsType == ucodeLsType)
        else $error("microcode type not selected");
    assert_any_cover_R11: assert (takenAny == (takenCond | reissue))
      else $error("taken outputs inconsistent");
  end
endmodule

// File: tb/branch_resolve_bench.sv
module branch_resolve_bench;
  logic       clk = 1'b0;
  logic [4:0] grpQual;
  logic       cmpEq, cmpGt, cmpLt, instValid, killInst, reissue;
  logic       ucodeWrPc, cacheReq, ucodeBusy;
  logic [1:0] rawLsType, ucodeLsType, lsType;
  logic       takenCond, takenAny;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  branch_resolve u_branch_resolve (
    .grpQual(grpQual), .cmpEq(cmpEq), .cmpGt(cmpGt), .cmpLt(cmpLt),
    .instValid(instValid), .killInst(killInst), .reissue(reissue),
    .ucodeWrPc(ucodeWrPc), .cacheReq(cacheReq), .ucodeBusy(ucodeBusy),
    .rawLsType(rawLsType), .ucodeLsType(ucodeLsType),
    .takenCond(takenCond), .takenAny(takenAny), .lsType(lsType)
  );

  function automatic logic refCond(input logic [4:0] g, input logic eq, input logic gt,
                                   input logic lt, input logic v, input logic k,
                                   input logic up);
    logic live;
    live = v & ~k;
    return live & ((g[4] & eq) | (g[3] & ~eq) | (g[2] & gt) | (g[1] & lt) | g[0] | up);
  endfunction

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply(input logic [4:0] g, input logic [2:0] f, input logic v,
                       input logic k, input logic r, input logic up);
    @(posedge clk);
    grpQual = g; {cmpEq, cmpGt, cmpLt} = f; instValid = v; killInst = k;
    reissue = r; ucodeWrPc = up;
    @(negedge clk);
  endtask

  task automatic run_class(input int cls, input string req);
    for (int f = 0; f < 8; f++) begin
      for (int vk = 0; vk < 4; vk++) begin
        logic [4:0] g;
        logic e;
        g = 5'(1 << cls);
        apply(g, 3'(f), vk[1], vk[0], 1'b0, 1'b0);
        e = refCond(g, f[2], f[1], f[0], vk[1], vk[0], 1'b0);
        check(req, {1'b0, takenCond}, {1'b0, e});
        check((vk == 2) ? req : "R7", {1'b0, takenAny}, {1'b0, e});
      end
    end
  endtask

  task automatic test_reset_state;
    grpQual = '0; {cmpEq, cmpGt, cmpLt} = '0; instValid = 0; killInst = 0;
    reissue = 0; ucodeWrPc = 0; cacheReq = 0; ucodeBusy = 0;
    rawLsType = 2'd2; ucodeLsType = 2'd1;
    @(negedge clk);
    check("R7", {1'b0, takenCond}, 2'd0);
    check("R7", {1'b0, takenAny}, 2'd0);
    check("R9", lsType, 2'd2);
  endtask

  task automatic test_ucode_pc_R6;
    for (int vk = 0; vk < 4; vk++)
      for (int f = 0; f < 8; f++) begin
        apply(5'd0, 3'(f), vk[1], vk[0], 1'b0, 1'b1);
        check("R6", {1'b0, takenCond}, {1'b0, vk == 2});
      end
  endtask

  task automatic test_reissue_R8;
    for (int g = 0; g < 32; g++)
      for (int f = 0; f < 8; f++) begin
        logic e;
        apply(5'(g), 3'(f), 1'b1, f[0], 1'b1, 1'b0);
        e = refCond(5'(g), f[2], f[1], f[0], 1'b1, f[0], 1'b0);
        check("R8", {1'b0, takenAny}, 2'd1);
        check("R8", {1'b0, takenCond}, {1'b0, e});
      end
  endtask

  task automatic test_multi_R10;
    for (int g = 0; g < 32; g++)
      for (int f = 0; f < 8; f++) begin
        logic e;
        apply(5'(g), 3'(f), 1'b1, 1'b0, 1'b0, 1'b0);
        e = refCond(5'(g), f[2], f[1], f[0], 1'b1, 1'b0, 1'b0);
        check("R10", {1'b0, takenCond}, {1'b0, e});
        check("R11", {1'b0, takenAny}, {1'b0, e});
      end
  endtask

  task automatic test_type_sel_R9;
    for (int s = 0; s < 4; s++)
      for (int t = 0; t < 16; t++) begin
        @(posedge clk);
        ucodeBusy = s[1]; cacheReq = s[0];
        rawLsType = t[3:2]; ucodeLsType = t[1:0];
        @(negedge clk);
        check("R9", lsType, (s == 2) ? 2'(t[1:0]) : 2'(t[3:2]));
      end
  endtask

  initial begin
    #200000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    test_reset_state();
    run_class(4, "R1");
    run_class(3, "R2");
    run_class(2, "R3");
    run_class(1, "R4");
    run_class(0, "R5");
    test_ucode_pc_R6();
    test_reissue_R8();
    test_multi_R10();
    test_type_sel_R9();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule